// File: doc/BRIEF.md
# Short-Circuit Test Pulse Sequencer

This block times one shot of a non-destructive short-circuit test on a power switch. It drives three gate commands: the device under test, a series protection switch that connects the device to the energy store, and a parallel protection switch that bypasses the device. It also issues a one-cycle acquisition trigger for the waveform recorder. It runs from a 100 MHz clock, so every programmable interval is a whole number of 10 ns cycles and can be changed in single 10 ns steps.

A host loads the test mode and four 16-bit cycle counts through a simple write port, for example from bytes received over a serial link. It then arms the sequencer and fires it. Two modes exist. In turn-on fault mode the series switch is already closed when the device gate is raised. In conduction fault mode the device first conducts load current with the series switch open, and the series switch is then closed to create the fault. Both modes end the short by opening the series switch and closing the parallel switch on the same clock edge. After a hold time all gates return to safe levels and a done pulse is issued. An abort from the host or from an external detector forces the cut levels at once and latches a fault state.

Top module: `sc_pulse_seq`

## Requirements
- R1: While reset is asserted and after it is released, all gate outputs, the acquisition trigger and the done pulse are 0, and status is 0 (idle).
- R2: An arm command in idle or done, with a valid configuration, moves status to 1 (armed). In turn-on fault mode (mode bit 0 = 0) the series gate is then 1 and the device and parallel gates 0; in conduction fault mode (mode bit 0 = 1) all three gates are 0.
- R3: An arm command is ignored and status stays 0 when the short duration is 0, the hold time is 0, or conduction fault mode is selected with a build time of 0. The build time is not checked in turn-on fault mode.
- R4: In turn-on fault mode, from the edge that samples the fire command and for exactly D cycles (D = short duration), the device and series gates are 1, the parallel gate is 0, and status is 2 (running).
- R5: In conduction fault mode, from the fire edge the device gate is 1 with the series gate 0 for exactly B cycles (B = build time), then the device and series gates are both 1 for exactly D cycles.
- R6: On the edge that ends the short, the series and device gates go to 0 and the parallel gate goes to 1 together; this lasts exactly H cycles (H = hold time).
- R7: After the hold, all gates are 0, status is 3 (done) and the done output is 1 for exactly one cycle. A fire command without a new arm has no effect.
- R8: The acquisition trigger is a one-cycle pulse in the run cycle whose index, counted from 0 at the first run cycle, equals the trigger offset; if the offset is not less than the run length (B in conduction mode, plus D plus H) no pulse occurs.
- R9: When the external or host abort is sampled high at an edge, from that edge the device and series gates are 0, the parallel gate is 1 and status is 4 (fault). Fault is left only by reset or by a clear command with both aborts low, which returns to idle.
- R10: Writes (address 0 mode bit 0, 1 build time, 2 short duration, 3 hold time, 4 trigger offset) are ignored while status is armed or running and accepted in idle, done and fault.
- R11: The series and parallel gates are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| arm_cmd | input | 1 | Arm request |
| fire_cmd | input | 1 | Start the armed shot |
| clear_cmd | input | 1 | Leave the fault state |
| host_abort | input | 1 | Abort from the host |
| ext_abort | input | 1 | Abort from an external detector |
| dut_gate | output | 1 | Gate command for the device under test |
| ser_gate | output | 1 | Gate command for the series protection switch |
| par_gate | output | 1 | Gate command for the parallel protection switch |
| acq_trig | output | 1 | One-cycle acquisition trigger |
| done_pulse | output | 1 | One-cycle end-of-shot pulse |
| status | output | 3 | 0 idle, 1 armed, 2 running, 3 done, 4 fault |

## Verification
The shot is swept over both modes with build times of 1 to 3, short durations of 1 to 3, hold times of 1 and 2 and trigger offsets of 0 to 5, comparing every gate, trigger, done and status bit in every cycle against phase boundaries computed from the sums of the counts; the smallest counts separate an off-by-one at each phase edge, and the offsets that reach past the run length show that a late trigger is suppressed. Zero counts in each checked field show which configurations arming refuses. Writes issued while armed and during the build phase, followed by a shot whose phase lengths must match the values loaded before, distinguish a locked register file from a live one. Aborts from each source in the armed and short phases, and a clear raised together with an abort, separate the latched fault from a momentary override.

// File: rtl/sc_seq_pkg.sv
package sc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_BUILD,
    ST_SHORT,
    ST_HOLD,
    ST_DONE,
    ST_FAULT
  } seq_state_t;

  localparam logic [2:0] ADDR_MODE  = 3'd0;
  localparam logic [2:0] ADDR_BUILD = 3'd1;
  localparam logic [2:0] ADDR_SHORT = 3'd2;
  localparam logic [2:0] ADDR_HOLD  = 3'd3;
  localparam logic [2:0] ADDR_TRIG  = 3'd4;

  localparam logic [2:0] STS_IDLE  = 3'd0;
  localparam logic [2:0] STS_ARMED = 3'd1;
  localparam logic [2:0] STS_RUN   = 3'd2;
  localparam logic [2:0] STS_DONE  = 3'd3;
  localparam logic [2:0] STS_FAULT = 3'd4;

endpackage

// File: rtl/sc_seq_regs.sv
module sc_seq_regs
  import sc_seq_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          lock_i,
  output logic          mode_o,
  output logic [CW-1:0] build_o,
  output logic [CW-1:0] short_o,
  output logic [CW-1:0] hold_o,
  output logic [CW-1:0] trig_o
);

  logic          wr_ok;
  logic          mode_en, build_en, short_en, hold_en, trig_en;
  logic          mode_q;
  logic [CW-1:0] build_q, short_q, hold_q, trig_q;

  always_comb begin
    wr_ok    = wr_en && !lock_i;
    mode_en  = wr_ok && (wr_addr == AW'(ADDR_MODE));
    build_en = wr_ok && (wr_addr == AW'(ADDR_BUILD));
    short_en = wr_ok && (wr_addr == AW'(ADDR_SHORT));
    hold_en  = wr_ok && (wr_addr == AW'(ADDR_HOLD));
    trig_en  = wr_ok && (wr_addr == AW'(ADDR_TRIG));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      build_q <= '0;
      short_q <= '0;
      hold_q  <= '0;
      trig_q  <= '0;
    end else begin
      if (mode_en)  mode_q  <= wr_data[0];
      if (build_en) build_q <= wr_data;
      if (short_en) short_q <= wr_data;
      if (hold_en)  hold_q  <= wr_data;
      if (trig_en)  trig_q  <= wr_data;
    end
  end

  assign mode_o  = mode_q;
  assign build_o = build_q;
  assign short_o = short_q;
  assign hold_o  = hold_q;
  assign trig_o  = trig_q;

  // R10
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_i && wr_en) |=> ($stable(mode_q) && $stable(build_q) && $stable(short_q)
                           && $stable(hold_q) && $stable(trig_q)));

endmodule

// File: rtl/sc_seq_ctrl.sv
module sc_seq_ctrl
  import sc_seq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          fire_i,
  input  logic          clear_i,
  input  logic          abort_i,
  input  logic          mode_i,
  input  logic [CW-1:0] build_i,
  input  logic [CW-1:0] short_i,
  input  logic [CW-1:0] hold_i,
  output logic          lock_o,
  output logic          run_next_o,
  output logic          start_next_o,
  output logic          dut_o,
  output logic          ser_o,
  output logic          par_o,
  output logic          done_o,
  output logic [2:0]    status_o
);

  seq_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          dut_q, ser_q, par_q, done_q;
  logic          dut_d, ser_d, par_d, done_d;
  logic          cfg_ok, cnt_zero;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    cnt_zero = (cnt_q == '0);
    cfg_ok   = (short_i != '0) && (hold_i != '0) && (!mode_i || (build_i != '0));
    unique case (state_q)
      ST_IDLE, ST_DONE: if (arm_i && cfg_ok) state_d = ST_ARMED;
      ST_ARMED: if (fire_i) begin
        if (mode_i) begin
          state_d = ST_BUILD;
          cnt_d   = build_i - CW'(1);
        end else begin
          state_d = ST_SHORT;
          cnt_d   = short_i - CW'(1);
        end
      end
      ST_BUILD: if (cnt_zero) begin
        state_d = ST_SHORT;
        cnt_d   = short_i - CW'(1);
      end else cnt_d = cnt_q - CW'(1);
      ST_SHORT: if (cnt_zero) begin
        state_d = ST_HOLD;
        cnt_d   = hold_i - CW'(1);
      end else cnt_d = cnt_q - CW'(1);
      ST_HOLD: if (cnt_zero) state_d = ST_DONE;
               else cnt_d = cnt_q - CW'(1);
      ST_FAULT: if (clear_i) state_d = ST_IDLE;
      default: state_d = ST_FAULT;
    endcase
    if (abort_i) state_d = ST_FAULT;
  end

  always_comb begin
    dut_d  = (state_d == ST_BUILD) || (state_d == ST_SHORT);
    ser_d  = (state_d == ST_SHORT) || ((state_d == ST_ARMED) && !mode_i);
    par_d  = (state_d == ST_HOLD) || (state_d == ST_FAULT);
    done_d = (state_d == ST_DONE) && (state_q == ST_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      dut_q   <= 1'b0;
      ser_q   <= 1'b0;
      par_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      dut_q   <= dut_d;
      ser_q   <= ser_d;
      par_q   <= par_d;
      done_q  <= done_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_IDLE:                    status_o = STS_IDLE;
      ST_ARMED:                   status_o = STS_ARMED;
      ST_BUILD, ST_SHORT, ST_HOLD: status_o = STS_RUN;
      ST_DONE:                    status_o = STS_DONE;
      default:                    status_o = STS_FAULT;
    endcase
  end

  assign lock_o       = arm_i || (state_q == ST_ARMED) || (state_q == ST_BUILD)
                        || (state_q == ST_SHORT) || (state_q == ST_HOLD);
  assign run_next_o   = (state_d == ST_BUILD) || (state_d == ST_SHORT) || (state_d == ST_HOLD);
  assign start_next_o = (state_q == ST_ARMED) && run_next_o;
  assign dut_o        = dut_q;
  assign ser_o        = ser_q;
  assign par_o        = par_q;
  assign done_o       = done_q;

  // R11
  no_dual_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_q && par_q));

  // R6
  cut_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_q) |-> (par_q && !dut_q));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9
  abort_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (par_q && !ser_q && !dut_q && (status_o == STS_FAULT)));

  // R9
  fault_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_FAULT) && !clear_i) |=> (state_q == ST_FAULT));

endmodule

// File: rtl/sc_seq_trig.sv
module sc_seq_trig #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_next_i,
  input  logic          start_next_i,
  input  logic [CW-1:0] offset_i,
  output logic          trig_o
);

  localparam int RW = CW + 2;

  logic [RW-1:0] rc_q, rc_d;
  logic          acq_q, acq_d;
  logic          rc_sat;

  always_comb begin
    rc_sat = (rc_q == {RW{1'b1}});
    if (start_next_i)              rc_d = '0;
    else if (run_next_i && !rc_sat) rc_d = rc_q + RW'(1);
    else                           rc_d = rc_q;
    acq_d = run_next_i && (rc_d == RW'(offset_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_q  <= '0;
      acq_q <= 1'b0;
    end else begin
      rc_q  <= rc_d;
      acq_q <= acq_d;
    end
  end

  assign trig_o = acq_q;

  // R8
  trig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_q |=> !acq_q);

endmodule

// File: rtl/sc_pulse_seq.sv
module sc_pulse_seq #(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          arm_cmd,
  input  logic          fire_cmd,
  input  logic          clear_cmd,
  input  logic          host_abort,
  input  logic          ext_abort,
  output logic          dut_gate,
  output logic          ser_gate,
  output logic          par_gate,
  output logic          acq_trig,
  output logic          done_pulse,
  output logic [2:0]    status
);

  logic          lock, run_next, start_next, mode;
  logic [CW-1:0] build_len, short_len, hold_len, trig_off;
  logic          abort_any;

  assign abort_any = host_abort || ext_abort;

  sc_seq_regs #(.CW(CW), .AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .lock_i  (lock),
    .mode_o  (mode),
    .build_o (build_len),
    .short_o (short_len),
    .hold_o  (hold_len),
    .trig_o  (trig_off)
  );

  sc_seq_ctrl #(.CW(CW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm_i        (arm_cmd),
    .fire_i       (fire_cmd),
    .clear_i      (clear_cmd),
    .abort_i      (abort_any),
    .mode_i       (mode),
    .build_i      (build_len),
    .short_i      (short_len),
    .hold_i       (hold_len),
    .lock_o       (lock),
    .run_next_o   (run_next),
    .start_next_o (start_next),
    .dut_o        (dut_gate),
    .ser_o        (ser_gate),
    .par_o        (par_gate),
    .done_o       (done_pulse),
    .status_o     (status)
  );

  sc_seq_trig #(.CW(CW)) u_trig (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_next_i   (run_next),
    .start_next_i (start_next),
    .offset_i     (trig_off),
    .trig_o       (acq_trig)
  );

endmodule

// File: tb/sc_pulse_seq_tb.sv
module sc_pulse_seq_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, arm_cmd, fire_cmd, clear_cmd, host_abort, ext_abort;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic        dut_gate, ser_gate, par_gate, acq_trig, done_pulse;
  logic [2:0]  status;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_pulse_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .arm_cmd(arm_cmd), .fire_cmd(fire_cmd), .clear_cmd(clear_cmd),
    .host_abort(host_abort), .ext_abort(ext_abort),
    .dut_gate(dut_gate), .ser_gate(ser_gate), .par_gate(par_gate),
    .acq_trig(acq_trig), .done_pulse(done_pulse), .status(status)
  );

  function automatic int pack_out(int d, int s, int p, int t, int dn, int st);
    return (d << 7) | (s << 6) | (p << 5) | (t << 4) | (dn << 3) | st;
  endfunction

  function automatic int cur_out();
    return pack_out(int'(dut_gate), int'(ser_gate), int'(par_gate),
                    int'(acq_trig), int'(done_pulse), int'(status));
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(int addr, int data);
    wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 16'(data);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic arm();
    arm_cmd = 1'b1; tick(); arm_cmd = 1'b0;
  endtask

  // Full shot; with inject set, writes are attempted while armed and during the first run cycle.
  task automatic run_shot(int mode, int b, int d, int h, int t, bit inject);
    int bm, total, exp, trig_seen, dual;
    string tag;
    wr(0, mode); wr(1, b); wr(2, d); wr(3, h); wr(4, t);
    arm();
    chk("R2 armed", cur_out(), pack_out(0, (mode == 0) ? 1 : 0, 0, 0, 0, 1));
    if (inject) begin
      wr(1, b + 3);
      chk("R10 write while armed keeps armed", int'(status), 1);
    end
    bm = (mode != 0) ? b : 0;
    total = bm + d + h;
    trig_seen = 0; dual = 0;
    fire_cmd = 1'b1; tick(); fire_cmd = 1'b0;
    for (int k = 0; k <= total + 1; k++) begin
      int tr;
      tr = ((k == t) && (t < total)) ? 1 : 0;
      if (k < bm) begin
        exp = pack_out(1, 0, 0, tr, 0, 2); tag = "R5 build";
      end else if (k < bm + d) begin
        exp = pack_out(1, 1, 0, tr, 0, 2); tag = (mode != 0) ? "R5 short" : "R4 short";
      end else if (k < total) begin
        exp = pack_out(0, 0, 1, tr, 0, 2); tag = "R6 hold";
      end else if (k == total) begin
        exp = pack_out(0, 0, 0, 0, 1, 3); tag = "R7 done";
      end else begin
        exp = pack_out(0, 0, 0, 0, 0, 3); tag = "R7 after done";
      end
      if (inject) tag = {tag, " R10"};
      chk(tag, cur_out(), exp);
      if (acq_trig) trig_seen++;
      if (ser_gate && par_gate) dual++;
      if (k <= total) begin
        if (inject && k == 0) wr(2, d + 4);
        else tick();
      end
    end
    chk("R8 trigger count", trig_seen, (t < total) ? 1 : 0);
    chk("R11 series and parallel overlap", dual, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    arm_cmd = 1'b0; fire_cmd = 1'b0; clear_cmd = 1'b0; host_abort = 1'b0; ext_abort = 1'b0;
    #(CLK_PERIOD * 3 + 1);
    chk("R1 in reset", cur_out(), 0);
    @(negedge clk); rst_n = 1'b1;
    tick();
    chk("R1 after reset", cur_out(), 0);

    // R3: zero fields refuse arming
    wr(0, 0); wr(1, 0); wr(2, 0); wr(3, 1);
    arm();
    chk("R3 zero short", cur_out(), 0);
    wr(2, 1); wr(3, 0);
    arm();
    chk("R3 zero hold", cur_out(), 0);
    wr(0, 1); wr(3, 1); wr(1, 0);
    arm();
    chk("R3 conduction zero build", cur_out(), 0);

    // R4..R8 sweep
    for (int mode = 0; mode < 2; mode++)
      for (int b = (mode == 0) ? 0 : 1; b <= ((mode == 0) ? 0 : 3); b++)
        for (int d = 1; d <= 3; d++)
          for (int h = 1; h <= 2; h++)
            for (int t = 0; t <= 5; t++)
              run_shot(mode, b, d, h, t, 1'b0);

    // R7: fire without re-arm
    fire_cmd = 1'b1; tick(); fire_cmd = 1'b0;
    chk("R7 fire without arm", cur_out(), pack_out(0, 0, 0, 0, 0, 3));
    tick();
    chk("R7 fire without arm later", cur_out(), pack_out(0, 0, 0, 0, 0, 3));

    // R10: writes while armed and running are ignored
    run_shot(1, 2, 2, 1, 9, 1'b1);

    // R9: external abort during short
    wr(0, 0); wr(2, 5); wr(3, 2); wr(4, 40);
    arm();
    fire_cmd = 1'b1; tick(); fire_cmd = 1'b0;
    tick(); tick();
    chk("R9 before abort", cur_out(), pack_out(1, 1, 0, 0, 0, 2));
    ext_abort = 1'b1; tick(); ext_abort = 1'b0;
    chk("R9 ext abort", cur_out(), pack_out(0, 0, 1, 0, 0, 4));
    tick(); tick(); tick();
    chk("R9 fault latched", cur_out(), pack_out(0, 0, 1, 0, 0, 4));
    arm();
    chk("R9 arm in fault ignored", cur_out(), pack_out(0, 0, 1, 0, 0, 4));
    clear_cmd = 1'b1; host_abort = 1'b1; tick(); host_abort = 1'b0; clear_cmd = 1'b0;
    chk("R9 clear with abort", cur_out(), pack_out(0, 0, 1, 0, 0, 4));
    clear_cmd = 1'b1; tick(); clear_cmd = 1'b0;
    chk("R9 cleared", cur_out(), 0);

    // R9: host abort while armed, R10 write accepted in fault
    arm();
    chk("R2 rearm turn-on", cur_out(), pack_out(0, 1, 0, 0, 0, 1));
    host_abort = 1'b1; tick(); host_abort = 1'b0;
    chk("R9 host abort armed", cur_out(), pack_out(0, 0, 1, 0, 0, 4));
    wr(2, 1);
    clear_cmd = 1'b1; tick(); clear_cmd = 1'b0;
    arm();
    fire_cmd = 1'b1; tick(); fire_cmd = 1'b0;
    chk("R10 fault write short", cur_out(), pack_out(1, 1, 0, 0, 0, 2));
    tick();
    chk("R10 fault write short ended", cur_out(), pack_out(0, 0, 1, 0, 0, 2));
    tick(); tick();
    chk("R7 done after fault recovery", cur_out(), pack_out(0, 0, 0, 0, 1, 3));

    // R9: abort in idle-like done state
    ext_abort = 1'b1; tick(); ext_abort = 1'b0;
    chk("R9 abort from done", cur_out(), pack_out(0, 0, 1, 0, 0, 4));
    clear_cmd = 1'b1; tick(); clear_cmd = 1'b0;
    run_shot(1, 1, 1, 1, 2, 1'b0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule